// File: doc/BRIEF.md
# Serial DAC Register Front-End

This block is the digital side of a serial-input digital-to-analog converter. A host writes 16-bit words over a three-wire serial link: an active-low frame input brackets each word, and the data bit is captured on every falling edge of the serial clock while the frame is low, most significant bit first. The code bits of a complete word go to a DAC holding register. The registered code drives the converter, which lies outside this block.

The level of the load strobe at the start of a frame picks the update mode. If the strobe is low, the holding register takes the new code as soon as the frame closes. If it is high, the code waits in a staging register until the strobe is pulled low. The shift register also drives an open-drain serial output. With no readback, this output repeats the input 16 serial clocks later, so several devices can be chained. With readback, the shift register is first loaded with the holding register contents. A clear input forces the output code to mid-scale and leaves every register untouched. A power-down input is registered and reported as a flag.

All inputs are taken to be synchronous to `clk`. The serial clock is oversampled, so it must stay in each level for at least two `clk` cycles. The parameter `RES` selects 12-bit or 14-bit resolution.

Top module: `serial_dac_front`

## Requirements
- R1: After the synchronous reset, `dac_code` is 0, `cleared` is 0, `powered_down` is 0 and `sdo_pull` is 1, because the shift register holds zeros.
- R2: While `frm_n` is low, each falling edge of `sck` shifts in `sdi`, most significant bit first. With `RES`=14 the code is word bits 13..0. With `RES`=12 it is word bits 13..2. All other bits are ignored.
- R3: If `ld_n` is low when `frm_n` falls, `dac_code` takes the new code on the first `clk` edge at which `frm_n` is seen high again. Before that edge it still shows the old code.
- R4: If `ld_n` is high when `frm_n` falls, the holding register is not changed when the frame closes. It takes the staged code on the first `clk` edge after the frame at which `ld_n` is low. The holding register changes only on a frame close or while `ld_n` is low.
- R5: A frame with fewer than 16 falling `sck` edges is discarded. A frame with more edges uses the last 16 bits shifted in.
- R6: Outside readback, `sdo_pull` is the inverse of the bit shifted in 16 falling edges earlier. It is 1 (pull low) for a 0 bit and 0 (released) for a 1 bit.
- R7: After `rdbk_n` falls, the next falling `sck` edge (with `frm_n` or `rdbk_n` low) loads the shift register with the holding register code, placed at the same bit positions it was written from, with bits 15..14 zero. Each later falling edge shifts this word out, most significant bit first.
- R8: While `clr_n` is low, `cleared` is 1 from the next `clk` edge and `dac_code` shows mid-scale (only bit RES-1 set). The holding register is not altered.
- R9: The clear state ends on the first `clk` edge with `clr_n` high and `ld_n` low. While `ld_n` stays high, the clear state holds after `clr_n` is released.
- R10: `powered_down` follows `pwr_dn` one `clk` edge later, and `pwr_dn` has no effect on the holding register or on `dac_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock; data is taken on its falling edge |
| frm_n | input | 1 | Active-low frame enable for a write word |
| sdi | input | 1 | Serial data in |
| ld_n | input | 1 | Active-low load strobe; also selects the update mode at frame start |
| rdbk_n | input | 1 | Active-low readback request |
| clr_n | input | 1 | Active-low clear |
| pwr_dn | input | 1 | Power-down request |
| sdo_pull | output | 1 | Open-drain serial output: 1 pulls the line low |
| dac_code | output | RES | Code driven to the converter |
| cleared | output | 1 | Output is forced to the clear code |
| powered_down | output | 1 | Registered power-down flag |

## Verification
A wrong bit count or a stale update mode shows at `dac_code` within one `clk` cycle of the frame closing: a code moves when it should wait, or stays when it should move. A corrupted shift register shows on `sdo_pull` after the next falling serial edge, and a chained word or readback word built from it has the wrong bits. A wrong clear state is visible on `cleared` and `dac_code` one cycle after `clr_n` or `ld_n` changes. A behavioural model compares all four outputs on every cycle, so any of these faults is reported in the cycle it first reaches a port.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int WORD_W   = 16;
    localparam int CODE_MAX = 14;
    localparam int CNT_W    = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [CODE_MAX-1:0] code_max_t;

    typedef enum logic {
        UPD_AUTO  = 1'b0,
        UPD_DEFER = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic frm_fall;
        logic frm_rise;
        logic sck_fall;
        logic rb_fall;
    } serial_ev_t;

    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    function automatic logic rose(input logic prev, input logic cur);
        return ~prev & cur;
    endfunction

endpackage

// File: rtl/dacfe_sampler.sv
module dacfe_sampler #(
    parameter int          N    = 3,
    parameter logic [N-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] prev
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                prev[i] <= IDLE[i];
            end else begin
                prev[i] <= sig[i];
            end
        end
    end

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frm_fall,
    input  logic      sck_fall,
    input  logic      rb_fall,
    input  logic      frm_low,
    input  logic      rb_low,
    input  logic      sdi,
    input  code_max_t rb_code,
    output logic      sdo_bit,
    output code_max_t payload,
    output logic      full
);

    word_t            sr;
    logic [CNT_W-1:0] cnt;
    logic             rb_pend;
    logic             shift_en;

    assign shift_en = sck_fall & (frm_low | rb_low);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            cnt     <= '0;
            rb_pend <= 1'b0;
        end else begin
            if (shift_en) begin
                if (rb_pend) begin
                    sr <= {2'b00, rb_code};
                end else begin
                    sr <= {sr[WORD_W-2:0], sdi};
                end
            end

            if (frm_fall) begin
                cnt <= '0;
            end else if (shift_en && frm_low && (cnt != CNT_W'(WORD_W))) begin
                cnt <= cnt + 1'b1;
            end

            if (rb_fall) begin
                rb_pend <= 1'b1;
            end else if (shift_en) begin
                rb_pend <= 1'b0;
            end
        end
    end

    assign sdo_bit = sr[WORD_W-1];
    assign payload = sr[CODE_MAX-1:0];
    assign full    = (cnt == CNT_W'(WORD_W));

endmodule

// File: rtl/dacfe_update.sv
module dacfe_update
    import dacfe_pkg::*;
#(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           frm_fall,
    input  logic           frm_rise,
    input  logic           ld_n,
    input  logic           full,
    input  logic [RES-1:0] code_in,
    output logic [RES-1:0] dac_q
);

    upd_mode_e      mode;
    logic [RES-1:0] stage;
    logic           pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= UPD_AUTO;
            stage <= '0;
            pend  <= 1'b0;
            dac_q <= '0;
        end else begin
            if (frm_rise && full) begin
                if (mode == UPD_AUTO) begin
                    dac_q <= code_in;
                    pend  <= 1'b0;
                end else begin
                    stage <= code_in;
                    pend  <= 1'b1;
                end
            end else if (pend && !ld_n) begin
                dac_q <= stage;
                pend  <= 1'b0;
            end

            if (frm_fall) begin
                mode <= ld_n ? UPD_DEFER : UPD_AUTO;
            end
        end
    end

endmodule

// File: rtl/dacfe_outstage.sv
module dacfe_outstage #(
    parameter int             RES      = 14,
    parameter logic [RES-1:0] CLR_CODE = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_n,
    input  logic           ld_n,
    input  logic           pwr_dn,
    input  logic [RES-1:0] dac_q,
    output logic [RES-1:0] dac_code,
    output logic           cleared,
    output logic           powered_down
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cleared      <= 1'b0;
            powered_down <= 1'b0;
        end else begin
            cleared      <= ~clr_n | (cleared & ld_n);
            powered_down <= pwr_dn;
        end
    end

    assign dac_code = cleared ? CLR_CODE : dac_q;

endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
    import dacfe_pkg::*;
#(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sck,
    input  logic           frm_n,
    input  logic           sdi,
    input  logic           ld_n,
    input  logic           rdbk_n,
    input  logic           clr_n,
    input  logic           pwr_dn,
    output logic           sdo_pull,
    output logic [RES-1:0] dac_code,
    output logic           cleared,
    output logic           powered_down
);

    localparam logic [RES-1:0] CLR_CODE = {1'b1, {(RES-1){1'b0}}};

    logic [2:0]     line_prev;
    serial_ev_t     ev;
    code_max_t      payload;
    code_max_t      rb_code;
    logic [RES-1:0] new_code;
    logic [RES-1:0] dac_reg;
    logic           sdo_bit;
    logic           full;

    // index 2: readback request, 1: serial clock, 0: frame enable
    dacfe_sampler #(.N(3), .IDLE(3'b101)) u_samp (
        .clk  (clk),
        .rst  (rst),
        .sig  ({rdbk_n, sck, frm_n}),
        .prev (line_prev)
    );

    assign ev.frm_fall = fell(line_prev[0], frm_n);
    assign ev.frm_rise = rose(line_prev[0], frm_n);
    assign ev.sck_fall = fell(line_prev[1], sck);
    assign ev.rb_fall  = fell(line_prev[2], rdbk_n);

    if (RES == CODE_MAX) begin : g_full_res
        assign new_code = payload;
        assign rb_code  = dac_reg;
    end else begin : g_low_res
        assign new_code = payload[CODE_MAX-1:CODE_MAX-RES];
        assign rb_code  = {dac_reg, {(CODE_MAX-RES){1'b0}}};
    end

    dacfe_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .frm_fall (ev.frm_fall),
        .sck_fall (ev.sck_fall),
        .rb_fall  (ev.rb_fall),
        .frm_low  (~frm_n),
        .rb_low   (~rdbk_n),
        .sdi      (sdi),
        .rb_code  (rb_code),
        .sdo_bit  (sdo_bit),
        .payload  (payload),
        .full     (full)
    );

    dacfe_update #(.RES(RES)) u_upd (
        .clk      (clk),
        .rst      (rst),
        .frm_fall (ev.frm_fall),
        .frm_rise (ev.frm_rise),
        .ld_n     (ld_n),
        .full     (full),
        .code_in  (new_code),
        .dac_q    (dac_reg)
    );

    dacfe_outstage #(.RES(RES), .CLR_CODE(CLR_CODE)) u_out (
        .clk          (clk),
        .rst          (rst),
        .clr_n        (clr_n),
        .ld_n         (ld_n),
        .pwr_dn       (pwr_dn),
        .dac_q        (dac_reg),
        .dac_code     (dac_code),
        .cleared      (cleared),
        .powered_down (powered_down)
    );

    assign sdo_pull = ~sdo_bit;

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
    parameter int RES = 14
) (
    input logic           clk,
    input logic           rst,
    input logic           ld_n,
    input logic           clr_n,
    input logic           pwr_dn,
    input logic           frm_rise,
    input logic [RES-1:0] dac_reg,
    input logic [RES-1:0] dac_code,
    input logic           cleared,
    input logic           powered_down
);

    localparam logic [RES-1:0] MID = {1'b1, {(RES-1){1'b0}}};

    // R8
    clear_force_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> cleared);

    // R8
    clear_code_chk: assert property (@(posedge clk) disable iff (rst)
        cleared |-> dac_code == MID);

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        !cleared |-> dac_code == dac_reg);

    // R9
    clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cleared && clr_n && ld_n) |=> cleared);

    // R9
    clear_release_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !ld_n) |=> !cleared);

    // R4
    dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frm_rise && ld_n) |=> $stable(dac_reg));

    // R10
    pd_set_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> powered_down);

    // R10
    pd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn |=> !powered_down);

endmodule

bind serial_dac_front dacfe_checker #(.RES(RES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ld_n         (ld_n),
    .clr_n        (clr_n),
    .pwr_dn       (pwr_dn),
    .frm_rise     (ev.frm_rise),
    .dac_reg      (dac_reg),
    .dac_code     (dac_code),
    .cleared      (cleared),
    .powered_down (powered_down)
);

// File: tb/serial_dac_front_tb.sv
`timescale 1ns/1ps
module serial_dac_front_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b1, frm_n = 1'b1, sdi = 1'b0, ld_n = 1'b0;
    logic rdbk_n = 1'b1, clr_n = 1'b1, pwr_dn = 1'b0;

    logic        sdo_pull, cleared, powered_down;
    logic [13:0] dac_code;
    logic        sdo12, clr12, pd12;
    logic [11:0] dac12;

    integer checks = 0;
    integer errors = 0;
    bit     done   = 0;

    always #4 clk = ~clk;

    serial_dac_front u_dut (
        .clk(clk), .rst(rst), .sck(sck), .frm_n(frm_n), .sdi(sdi), .ld_n(ld_n),
        .rdbk_n(rdbk_n), .clr_n(clr_n), .pwr_dn(pwr_dn), .sdo_pull(sdo_pull),
        .dac_code(dac_code), .cleared(cleared), .powered_down(powered_down)
    );

    serial_dac_front #(.RES(12)) u_dut12 (
        .clk(clk), .rst(rst), .sck(sck), .frm_n(frm_n), .sdi(sdi), .ld_n(ld_n),
        .rdbk_n(rdbk_n), .clr_n(clr_n), .pwr_dn(pwr_dn), .sdo_pull(sdo12),
        .dac_code(dac12), .cleared(clr12), .powered_down(pd12)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          mq[$];
    logic [13:0] m_dac, m_stage;
    bit          m_pend, m_defer, m_rbp, m_hold, m_pd;
    bit          m_frm, m_sck, m_rb;
    integer      m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            for (int i = 0; i < 16; i++) mq.push_back(1'b0);
            m_dac = 0; m_stage = 0; m_pend = 0; m_defer = 0; m_rbp = 0;
            m_hold = 0; m_pd = 0; m_frm = 1; m_sck = 0; m_rb = 1; m_cnt = 0;
        end else begin
            logic [13:0] old_dac;
            logic [15:0] w, rbw;
            bit ffall, frise, sfall, rfall, shift;
            old_dac = m_dac;
            ffall = m_frm && !frm_n;
            frise = !m_frm && frm_n;
            sfall = m_sck && !sck;
            rfall = m_rb && !rdbk_n;
            shift = sfall && (!frm_n || !rdbk_n);
            w = 0;
            foreach (mq[i]) w = {w[14:0], mq[i]};
            if (frise && m_cnt >= 16) begin
                if (!m_defer) begin m_dac = w[13:0]; m_pend = 0; end
                else begin m_stage = w[13:0]; m_pend = 1; end
            end else if (m_pend && !ld_n) begin
                m_dac = m_stage; m_pend = 0;
            end
            if (ffall) m_defer = ld_n;
            if (shift) begin
                if (m_rbp) begin
                    rbw = {2'b00, old_dac};
                    mq.delete();
                    for (int i = 15; i >= 0; i--) mq.push_back(rbw[i]);
                end else begin
                    mq.push_back(sdi);
                    void'(mq.pop_front());
                end
            end
            if (ffall) m_cnt = 0;
            else if (shift && !frm_n && m_cnt < 16) m_cnt++;
            if (rfall) m_rbp = 1;
            else if (shift) m_rbp = 0;
            m_hold = !clr_n || (m_hold && ld_n);
            m_pd = pwr_dn;
            m_frm = frm_n; m_sck = sck; m_rb = rdbk_n;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 dac_code vs model", dac_code, m_hold ? 14'h2000 : m_dac);
            chk("R9 cleared vs model", cleared, m_hold);
            chk("R6 sdo_pull vs model", sdo_pull, !mq[0]);
            chk("R10 powered_down vs model", powered_down, m_pd);
        end
    end

    // ---------------- stimulus ----------------
    logic [15:0] cap;
    logic [13:0] before_rise;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_word(input logic [31:0] w, input int nb, input logic ldv);
        ld_n = ldv;
        tick(1);
        frm_n = 1'b0;
        tick(2);
        for (int i = nb - 1; i >= 0; i--) begin
            sdi = w[i];
            tick(2);
            cap = {cap[14:0], ~sdo_pull};
            sck = 1'b0;
            tick(2);
            sck = 1'b1;
        end
        tick(2);
        before_rise = dac_code;
        frm_n = 1'b1;
        #1;
        chk("R3 code unchanged before frame close is seen", dac_code, before_rise);
        tick(3);
    endtask

    task automatic read_back(output logic [15:0] got);
        got = '0;
        rdbk_n = 1'b0;
        sdi = 1'b0;
        tick(2);
        for (int i = 0; i < 16; i++) begin
            sck = 1'b0;
            tick(2);
            got = {got[14:0], ~sdo_pull};
            sck = 1'b1;
            tick(2);
        end
        rdbk_n = 1'b1;
        tick(2);
    endtask

    initial begin
        logic [15:0] rb;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 dac_code after reset", dac_code, 14'h0000);
        chk("R1 cleared after reset", cleared, 1'b0);
        chk("R1 powered_down after reset", powered_down, 1'b0);
        chk("R1 sdo_pull after reset", sdo_pull, 1'b1);

        // R2 R3: auto update, top bits ignored; 12-bit instance takes bits 13..2
        send_word(32'h0000_EA5B, 16, 1'b0);
        chk("R2 R3 14-bit code after auto frame", dac_code, 14'h2A5B);
        chk("R2 12-bit code from bits 13..2", dac12, 12'hA96);

        // R7 readback: bits 15..14 zero
        read_back(rb);
        chk("R7 readback word", rb, 16'h2A5B);
        chk("R7 readback leaves code", dac_code, 14'h2A5B);

        // R6 daisy chain, R4 deferred update
        send_word(32'h0000_9C01, 16, 1'b0);
        chk("R2 second auto word", dac_code, 14'h1C01);
        send_word(32'h0000_1234, 16, 1'b1);
        chk("R6 chained output repeats previous word", cap, 16'h9C01);
        chk("R6 sdo after frame shows new MSB", sdo_pull, 1'b1);
        tick(4);
        chk("R4 no update at frame close in deferred mode", dac_code, 14'h1C01);
        ld_n = 1'b0;
        tick(2);
        chk("R4 update on load strobe low", dac_code, 14'h1234);

        // R5 short and long frames
        send_word(32'h0000_03FF, 10, 1'b0);
        chk("R5 short frame discarded", dac_code, 14'h1234);
        send_word(32'h000F_0ABC, 20, 1'b0);
        chk("R5 long frame keeps last 16 bits", dac_code, 14'h0ABC);

        // R8 R9 clear
        ld_n = 1'b1;
        clr_n = 1'b0;
        tick(2);
        chk("R8 clear forces mid-scale", dac_code, 14'h2000);
        chk("R8 cleared flag", cleared, 1'b1);
        clr_n = 1'b1;
        tick(3);
        chk("R9 clear holds with load strobe high", cleared, 1'b1);
        ld_n = 1'b0;
        tick(2);
        chk("R8 R9 register kept across clear", dac_code, 14'h0ABC);
        clr_n = 1'b0;
        tick(2);
        chk("R8 clear with strobe tied low", dac_code, 14'h2000);
        clr_n = 1'b1;
        tick(2);
        chk("R9 automatic return on release", dac_code, 14'h0ABC);

        // R10 power-down
        pwr_dn = 1'b1;
        tick(2);
        chk("R10 power-down flag", powered_down, 1'b1);
        chk("R10 code unaffected by power-down", dac_code, 14'h0ABC);
        send_word(32'h0000_0111, 16, 1'b0);
        chk("R10 writes still land while powered down", dac_code, 14'h0111);
        pwr_dn = 1'b0;
        tick(2);
        chk("R10 power-down flag released", powered_down, 1'b0);

        tick(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule